// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block keeps the sixteen most useful virtual-to-physical page translations close to the pipeline. In the same cycle as a lookup, it compares the 20-bit virtual page number against every stored tag. A match returns the physical address. When nothing matches, the block raises a miss, and a page walker or a software handler then finds the translation and writes it back through the fill port.

Stores that hit mark their entry dirty. When that page is later replaced, it can then be recognised as needing write-back. Filling and flushing change the mapping, so they are honoured only while the privilege input reports kernel mode. A fill goes to an empty slot when one exists. Otherwise the victim comes from a binary pseudo-LRU tree, which every hit and every fill refreshes.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is empty, so every lookup reports a miss.
- R2: A lookup (`lk_valid`=1) hits when a valid entry's tag equals `lk_vaddr[31:12]`. The result appears in the same cycle and reflects contents written before the current clock edge. `lk_hit` and `lk_miss` are both low when no lookup is presented.
- R3: On a hit, `lk_paddr` is the entry's 18-bit physical page number above `lk_vaddr[11:0]`. On a miss it is zero.
- R4: A presented lookup with no matching valid entry drives `lk_miss`=1 and `lk_hit`=0.
- R5: A lookup with `lk_store`=1 that hits sets that entry's dirty flag. `lk_dirty` shows the flag from the next cycle on. A fresh fill leaves the flag clear.
- R6: `fill_en` and `inval_all` take effect only when `kernel_mode`=1. Otherwise they leave every entry unchanged.
- R7: A fill whose page number equals a valid entry's tag rewrites that entry, with a new frame number and a clear dirty flag. No second copy is made, so at most one entry ever matches.
- R8: A fill of a new page number goes to the lowest-numbered empty entry if any entry is empty. Otherwise it goes to the pseudo-LRU victim.
- R9: The pseudo-LRU is a 15-node binary tree. Every hit and every fill steers each node on the entry's path toward the other half, and the victim is found by following the nodes from the root.
- R10: With `kernel_mode`=1, `inval_all` empties every entry at one edge. A fill in the same cycle is dropped.
- R11: When a store hit and a fill fall in the same cycle, a fill of the same page number wins: the frame is new and the dirty flag is clear. A fill to another entry does not disturb the dirty flag the store sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kernel_mode | input | 1 | 1 = privileged; enables fill and flush |
| lk_valid | input | 1 | Lookup presented this cycle |
| lk_store | input | 1 | Lookup is for a store |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent; walk required |
| lk_dirty | output | 1 | Dirty flag of the hit entry |
| lk_paddr | output | 30 | Physical address on hit, zero otherwise |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 20 | Virtual page number to write |
| fill_ppn | input | 18 | Physical page number to write |
| inval_all | input | 1 | Empty every entry |

## Verification
Dirty marking from a store hit and a kernel fill can land on the same edge. The bench provokes this twice. In the first case the store hits the very page being refilled, and the refill must win, leaving a new frame with a clean flag. In the second, just after a flush, the store hits one page while a different page fills the next empty slot, and both effects must persist. Each case is judged by lookups in the following cycles, which compare the frame number and the dirty flag against queued expectations.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int PPN_W   = 18;
    localparam int ENTRIES = 16;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PA_W    = PPN_W + OFF_W;
    localparam int IDX_W   = $clog2(ENTRIES);

    typedef struct packed {
        logic             vld;
        logic             dty;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_ent_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = ENTRIES
) (
    input  tlb_ent_t [N-1:0]   ents,
    input  logic [VPN_W-1:0]   key,
    output logic [N-1:0]       match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = ents[g].vld && (ents[g].vpn == key);
    end
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ta_en,
    input  logic [IW-1:0] ta_idx,
    input  logic          tb_en,
    input  logic [IW-1:0] tb_idx,
    output logic [IW-1:0] victim
);
    typedef struct packed {
        logic [N-2:0] tree;
    } plru_st_t;

    plru_st_t st_d, st_q;

    function automatic logic [N-2:0] f_touch(input logic [N-2:0] t, input logic [IW-1:0] idx);
        logic [N-2:0] r;
        int node;
        r = t;
        node = 1;
        for (int l = 0; l < IW; l++) begin
            r[node-1] = ~idx[IW-1-l];
            node = node * 2 + int'(idx[IW-1-l]);
        end
        return r;
    endfunction

    always_comb begin
        int node;
        st_d = st_q;
        if (ta_en) st_d.tree = f_touch(st_d.tree, ta_idx);
        if (tb_en) st_d.tree = f_touch(st_d.tree, tb_idx);
        victim = '0;
        node = 1;
        for (int l = 0; l < IW; l++) begin
            victim[IW-1-l] = st_q.tree[node-1];
            node = node * 2 + int'(st_q.tree[node-1]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tlb_alloc.sv
module tlb_alloc #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vld_vec,
    input  logic [IW-1:0] lru_victim,
    output logic [IW-1:0] slot
);
    always_comb begin
        slot = lru_victim;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_vec[i]) slot = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kernel_mode,
    input  logic             lk_valid,
    input  logic             lk_store,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_dirty,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             inval_all
);
    typedef struct packed {
        tlb_ent_t [ENTRIES-1:0] ent;
    } tlb_st_t;

    tlb_st_t st_d, st_q;

    logic [ENTRIES-1:0] hit_vec, fmatch_vec, vld_vec, dty_vec;
    logic [IDX_W-1:0]   hit_idx, fmatch_idx, alloc_idx, lru_victim, fill_idx;
    logic               hit_any, fill_dup, wr_ok, inv_ok, store_upd;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
        assign vld_vec[g] = st_q.ent[g].vld;
        assign dty_vec[g] = st_q.ent[g].dty;
    end

    tlb_match #(.N(ENTRIES)) i_lk_match (
        .ents  (st_q.ent),
        .key   (lk_vaddr[VA_W-1:OFF_W]),
        .match (hit_vec)
    );

    tlb_match #(.N(ENTRIES)) i_fill_match (
        .ents  (st_q.ent),
        .key   (fill_vpn),
        .match (fmatch_vec)
    );

    tlb_alloc #(.N(ENTRIES)) i_alloc (
        .vld_vec    (vld_vec),
        .lru_victim (lru_victim),
        .slot       (alloc_idx)
    );

    tlb_plru #(.N(ENTRIES)) i_plru (
        .clk    (clk),
        .rst_n  (rst_n),
        .ta_en  (lk_valid && hit_any),
        .ta_idx (hit_idx),
        .tb_en  (wr_ok),
        .tb_idx (fill_idx),
        .victim (lru_victim)
    );

    always_comb begin
        hit_idx    = '0;
        fmatch_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i])    hit_idx    = hit_idx | IDX_W'(i);
            if (fmatch_vec[i]) fmatch_idx = fmatch_idx | IDX_W'(i);
        end
        hit_any   = |hit_vec;
        fill_dup  = |fmatch_vec;
        fill_idx  = fill_dup ? fmatch_idx : alloc_idx;
        inv_ok    = kernel_mode && inval_all;
        wr_ok     = kernel_mode && fill_en && !inval_all;
        store_upd = lk_valid && lk_store && hit_any;

        st_d = st_q;
        if (store_upd) st_d.ent[hit_idx].dty = 1'b1;
        if (wr_ok) begin
            st_d.ent[fill_idx].vld = 1'b1;
            st_d.ent[fill_idx].dty = 1'b0;
            st_d.ent[fill_idx].vpn = fill_vpn;
            st_d.ent[fill_idx].ppn = fill_ppn;
        end
        if (inv_ok) begin
            for (int i = 0; i < ENTRIES; i++) st_d.ent[i].vld = 1'b0;
        end

        lk_hit   = lk_valid && hit_any;
        lk_miss  = lk_valid && !hit_any;
        lk_dirty = lk_hit && st_q.ent[hit_idx].dty;
        lk_paddr = lk_hit ? {st_q.ent[hit_idx].ppn, lk_vaddr[OFF_W-1:0]} : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               kernel_mode,
    input logic               lk_valid,
    input logic               lk_store,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic [PA_W-1:0]    lk_paddr,
    input logic               fill_en,
    input logic               inval_all,
    input logic [ENTRIES-1:0] vld_vec,
    input logic [ENTRIES-1:0] dty_vec,
    input logic [ENTRIES-1:0] hit_vec
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));

    p_hit_xor_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit != lk_miss));

    p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    p_store_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_store && !(kernel_mode && (fill_en || inval_all)))
        |=> ((dty_vec & $past(hit_vec)) == $past(hit_vec)));

    p_user_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !kernel_mode |=> (vld_vec == $past(vld_vec)));

    p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_flush_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (kernel_mode && inval_all) |=> (vld_vec == '0));
endmodule

bind tlb_xlate tlb_xlate_chk i_chk (.*);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
    import tlb_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             kernel_mode = 1'b1;
    logic             lk_valid = 1'b0;
    logic             lk_store = 1'b0;
    logic [VA_W-1:0]  lk_vaddr = '0;
    logic             lk_hit, lk_miss, lk_dirty;
    logic [PA_W-1:0]  lk_paddr;
    logic             fill_en = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic             inval_all = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [VA_W-1:0]  va;
        logic             hit;
        logic [PPN_W-1:0] ppn;
        logic             dty;
        string            rq;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    tlb_xlate i_tlb_xlate (
        .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode),
        .lk_valid(lk_valid), .lk_store(lk_store), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_dirty(lk_dirty), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .inval_all(inval_all)
    );

    function automatic logic [VPN_W-1:0] vp(input int k);
        return VPN_W'(32'hA0000 + k * 32'h111);
    endfunction

    function automatic logic [PPN_W-1:0] pp(input int k);
        return PPN_W'(32'h100 + k * 7);
    endfunction

    // Monitor: pops one expectation per presented lookup.
    always @(negedge clk) begin
        if (rst_n && lk_valid) begin
            exp_t e;
            logic [PA_W-1:0] epa;
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: lookup without expectation");
            end else begin
                e = sb.pop_front();
                epa = e.hit ? {e.ppn, e.va[OFF_W-1:0]} : '0;
                checks++;
                if (lk_hit !== e.hit || lk_miss !== !e.hit || lk_paddr !== epa ||
                    lk_dirty !== (e.hit & e.dty)) begin
                    errors++;
                    $display("FAIL %s: va=%h got hit=%b miss=%b pa=%h dty=%b exp hit=%b pa=%h dty=%b",
                             e.rq, e.va, lk_hit, lk_miss, lk_paddr, lk_dirty,
                             e.hit, epa, e.hit & e.dty);
                end
            end
        end
    end

    task automatic drive(input logic lv, input logic st, input logic [VPN_W-1:0] lvpn,
                         input logic fe, input logic [VPN_W-1:0] fv, input logic [PPN_W-1:0] fp,
                         input logic inv, input logic kern,
                         input logic ehit, input logic [PPN_W-1:0] eppn, input logic edty,
                         input string rq);
        exp_t e;
        @(posedge clk);
        #1;
        lk_valid = lv; lk_store = st;
        lk_vaddr = {lvpn, OFF_W'(12'h5A3 + lvpn[3:0])};
        fill_en = fe; fill_vpn = fv; fill_ppn = fp;
        inval_all = inv; kernel_mode = kern;
        if (lv) begin
            e.va = lk_vaddr; e.hit = ehit; e.ppn = eppn; e.dty = edty; e.rq = rq;
            sb.push_back(e);
        end
    endtask

    task automatic look(input logic [VPN_W-1:0] v, input logic ehit,
                        input logic [PPN_W-1:0] eppn, input logic edty, input string rq);
        drive(1'b1, 1'b0, v, 1'b0, '0, '0, 1'b0, 1'b1, ehit, eppn, edty, rq);
    endtask

    task automatic put(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p);
        drive(1'b0, 1'b0, '0, 1'b1, v, p, 1'b0, 1'b1, 1'b0, '0, 1'b0, "");
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b1, 1'b0, '0, 1'b0, "");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset
        look(vp(0), 1'b0, '0, 1'b0, "R1");
        look(vp(5), 1'b0, '0, 1'b0, "R1");

        // R7: refill of same page overwrites; R8: 16 distinct fills into empty slots
        put(vp(0), pp(99));
        put(vp(0), pp(0));
        look(vp(0), 1'b1, pp(0), 1'b0, "R7");
        for (int k = 1; k < 16; k++) put(vp(k), pp(k));
        for (int k = 0; k < 16; k++) look(vp(k), 1'b1, pp(k), 1'b0, "R7_R3");

        // R9: tree victim after touching 0..15 then 0 is entry 8, then entry 4
        look(vp(0), 1'b1, pp(0), 1'b0, "R9");
        put(vp(40), pp(40));
        look(vp(8), 1'b0, '0, 1'b0, "R9");
        look(vp(40), 1'b1, pp(40), 1'b0, "R8_R9");
        put(vp(41), pp(41));
        look(vp(4), 1'b0, '0, 1'b0, "R9");
        look(vp(41), 1'b1, pp(41), 1'b0, "R8_R9");

        // R5: store hit sets dirty, visible next cycle; refill clears it
        drive(1'b1, 1'b1, vp(3), 1'b0, '0, '0, 1'b0, 1'b1, 1'b1, pp(3), 1'b0, "R5");
        look(vp(3), 1'b1, pp(3), 1'b1, "R5");
        drive(1'b1, 1'b1, vp(50), 1'b0, '0, '0, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R4");
        put(vp(3), pp(50));
        look(vp(3), 1'b1, pp(50), 1'b0, "R5_R7");

        // R6: user mode ignores fill and flush
        drive(1'b0, 1'b0, '0, 1'b1, vp(60), pp(60), 1'b0, 1'b0, 1'b0, '0, 1'b0, "");
        look(vp(60), 1'b0, '0, 1'b0, "R6");
        drive(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b1, 1'b0, 1'b0, '0, 1'b0, "");
        look(vp(0), 1'b1, pp(0), 1'b0, "R6");

        // R2: lookup during its own fill sees old contents
        drive(1'b1, 1'b0, vp(70), 1'b1, vp(70), pp(70), 1'b0, 1'b1, 1'b0, '0, 1'b0, "R2");
        look(vp(70), 1'b1, pp(70), 1'b0, "R2");

        // R11: store hit and refill of the same page in one cycle: refill wins
        drive(1'b1, 1'b1, vp(3), 1'b1, vp(3), pp(77), 1'b0, 1'b1, 1'b1, pp(50), 1'b0, "R11");
        look(vp(3), 1'b1, pp(77), 1'b0, "R11");

        // R10: flush wins over same-cycle fill
        drive(1'b0, 1'b0, '0, 1'b1, vp(80), pp(80), 1'b1, 1'b1, 1'b0, '0, 1'b0, "");
        look(vp(0), 1'b0, '0, 1'b0, "R10");
        look(vp(80), 1'b0, '0, 1'b0, "R10");
        look(vp(3), 1'b0, '0, 1'b0, "R10");

        // R11/R8: store hit on one page while another fills an empty slot
        put(vp(90), pp(90));
        drive(1'b1, 1'b1, vp(90), 1'b1, vp(91), pp(91), 1'b0, 1'b1, 1'b1, pp(90), 1'b0, "R11");
        look(vp(90), 1'b1, pp(90), 1'b1, "R11");
        look(vp(91), 1'b1, pp(91), 1'b0, "R8_R11");

        idle();
        idle();
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule